// File: doc/BRIEF.md
# Prioritized Multifunction Shift Register

A clocked register of parameterizable width with five operations: synchronous clear, synchronous set to all ones, parallel load, shift left with a serial input bit, and hold. Four request inputs select the operation. More than one of them may be high in the same cycle, and a fixed priority settles the conflict: clear wins over set, set over load, and load over shift. When no request is high the register keeps its value.

Inside, a small combinational decoder turns the four requests into a 3-bit select code. One multiplexer per bit uses that code to pick the bit's next value. Every change of state takes place on the rising clock edge, and there is no asynchronous reset. A system brings the register to a known state by asserting the clear request.

Top module: `prio_shift_reg`

## Requirements
- R1: When `clr` is high at a rising edge, `q` becomes all zeros after that edge, whatever `set`, `ld`, `shl`, `sin` and `d` are.
- R2: When `set` is high and `clr` is low at a rising edge, `q` becomes all ones, whatever `ld`, `shl`, `sin` and `d` are.
- R3: When `ld` is high and `clr` and `set` are low at a rising edge, `q` takes `d`, and `shl` and `sin` have no effect.
- R4: When `shl` is the only request high at a rising edge, bit i of `q` takes the old bit i-1 for i from 1 to WIDTH-1, bit 0 takes `sin`, and the old top bit is dropped.
- R5: When no request is high at a rising edge, `q` keeps its value.
- R6: The internal select code is 000 for hold, 001 for load, 010 for shift left, 011 for clear and 100 for set. Exactly one operation is active in each cycle. `d` affects `q` only during a load, and `sin` affects `q` only during a shift.
- R7: `q` changes only on a rising clock edge. Changes on the inputs between edges leave `q` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| clr | input | 1 | Synchronous clear request (highest priority) |
| set | input | 1 | Synchronous set-to-ones request |
| ld | input | 1 | Parallel load request |
| shl | input | 1 | Shift-left request (lowest priority) |
| sin | input | 1 | Serial bit shifted into bit 0 |
| d | input | WIDTH | Parallel load data |
| q | output | WIDTH | Register contents |

## Verification
On every clock after the first clear, the assertions check that the operation taken follows the priority order and that its result is correct: zeros, ones, the loaded data, the shifted value or the held value. They also check that the decoded operation strobes are never high two at a time. Two properties need the bench's scenarios: that `q` stays still between edges while the inputs change, and that `d` and `sin` have no effect outside their own operation. The bench shows these by sweeping all sixteen request combinations from several starting values, and by running a long random sequence against an arithmetic model.

// File: rtl/msr_pkg.sv
package msr_pkg;

  typedef enum logic [2:0] {
    SEL_HOLD = 3'b000,
    SEL_LOAD = 3'b001,
    SEL_SHL  = 3'b010,
    SEL_CLR  = 3'b011,
    SEL_SET  = 3'b100
  } msr_sel_e;

  // Resolve the request lines into the mux select code (clr > set > ld > shl).
  function automatic msr_sel_e msr_select(input logic clr, input logic set,
                                          input logic ld, input logic shl);
    logic s2, s1, s0;
    s2 = !clr & set;
    s1 = (!clr & !set & !ld & shl) | clr;
    s0 = (!clr & !set & ld) | clr;
    return msr_sel_e'({s2, s1, s0});
  endfunction

  // Five-way pick of one bit's next value.
  function automatic logic msr_pick(input msr_sel_e sel, input logic hold_v,
                                    input logic load_v, input logic shift_v);
    logic r;
    case (sel)
      SEL_LOAD: r = load_v;
      SEL_SHL:  r = shift_v;
      SEL_CLR:  r = 1'b0;
      SEL_SET:  r = 1'b1;
      default:  r = hold_v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/msr_sel_map.sv
module msr_sel_map
  import msr_pkg::*;
(
  input  logic     clr,
  input  logic     set,
  input  logic     ld,
  input  logic     shl,
  output msr_sel_e sel
);
  always_comb sel = msr_select(clr, set, ld, shl);
endmodule

// File: rtl/msr_bit_mux.sv
module msr_bit_mux
  import msr_pkg::*;
(
  input  msr_sel_e sel,
  input  logic     hold_v,
  input  logic     load_v,
  input  logic     shift_v,
  output logic     nxt
);
  always_comb nxt = msr_pick(sel, hold_v, load_v, shift_v);
endmodule

// File: rtl/prio_shift_reg.sv
module prio_shift_reg
  import msr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             set,
  input  logic             ld,
  input  logic             shl,
  input  logic             sin,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int TOP = WIDTH - 1;

  msr_sel_e         sel_w;
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] nxt_w;
  logic [WIDTH-1:0] shift_src_w;

  // Decoded operation strobes, brought out for the checker.
  logic op_hold_w, op_load_w, op_shl_w, op_clr_w, op_set_w;

  msr_sel_map u_sel (
    .clr (clr),
    .set (set),
    .ld  (ld),
    .shl (shl),
    .sel (sel_w)
  );

  always_comb begin
    op_hold_w = (sel_w == SEL_HOLD);
    op_load_w = (sel_w == SEL_LOAD);
    op_shl_w  = (sel_w == SEL_SHL);
    op_clr_w  = (sel_w == SEL_CLR);
    op_set_w  = (sel_w == SEL_SET);
  end

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      if (gi == 0) begin : g_lsb
        assign shift_src_w[gi] = sin;
      end else begin : g_up
        assign shift_src_w[gi] = q_r[gi-1];
      end

      msr_bit_mux u_mux (
        .sel     (sel_w),
        .hold_v  (q_r[gi]),
        .load_v  (d[gi]),
        .shift_v (shift_src_w[gi]),
        .nxt     (nxt_w[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    q_r <= nxt_w;
  end

  assign q = q_r;

  // The top bit leaves on a shift; kept as a named wire for observation.
  logic drop_bit_w;
  assign drop_bit_w = q_r[TOP];

endmodule

// File: rtl/msr_check.sv
module msr_check
  import msr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clr,
  input logic             set,
  input logic             ld,
  input logic             shl,
  input logic             sin,
  input logic [WIDTH-1:0] d,
  input logic [WIDTH-1:0] q,
  input logic             op_hold,
  input logic             op_load,
  input logic             op_shl,
  input logic             op_clr,
  input logic             op_set,
  input logic             drop_bit
);
  // No reset port: the state is defined after the first clear, so arm then.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | clr;

  logic unused_drop;
  assign unused_drop = drop_bit;

  assert_clear_R1: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (q == '0));

  assert_set_R2: assert property (@(posedge clk) disable iff (!armed)
    (!clr && set) |=> (q == '1));

  assert_load_R3: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !set && ld) |=> (q == $past(d)));

  assert_shift_R4: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !set && !ld && shl) |=> (q == {$past(q[WIDTH-2:0]), $past(sin)}));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !set && !ld && !shl) |=> $stable(q));

  assert_one_op_R6: assert property (@(posedge clk) disable iff (!armed)
    $countones({op_hold, op_load, op_shl, op_clr, op_set}) == 1);

  assert_clr_wins_R6: assert property (@(posedge clk) disable iff (!armed)
    clr |-> (op_clr && !op_set && !op_load));

endmodule

bind prio_shift_reg msr_check #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .clr      (clr),
  .set      (set),
  .ld       (ld),
  .shl      (shl),
  .sin      (sin),
  .d        (d),
  .q        (q),
  .op_hold  (op_hold_w),
  .op_load  (op_load_w),
  .op_shl   (op_shl_w),
  .op_clr   (op_clr_w),
  .op_set   (op_set_w),
  .drop_bit (drop_bit_w)
);

// File: tb/prio_shift_reg_bench.sv
`timescale 1ns/1ps
module prio_shift_reg_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr = 1'b0, set = 1'b0, ld = 1'b0, shl = 1'b0, sin = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [W-1:0] model;

  always #4 clk = ~clk;

  prio_shift_reg #(.WIDTH(W)) u_prio_shift_reg (
    .clk(clk), .clr(clr), .set(set), .ld(ld), .shl(shl),
    .sin(sin), .d(d), .q(q)
  );

  task automatic check(input string tag, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: q=%b expected=%b", tag, got, exp);
    end
  endtask

  // Expected next value, from the priority rules alone.
  function automatic logic [W-1:0] ref_next(input logic [3:0] c, input logic s,
                                            input logic [W-1:0] dv,
                                            input logic [W-1:0] cur);
    if (c[3])      return '0;
    else if (c[2]) return '1;
    else if (c[1]) return dv;
    else if (c[0]) return (cur << 1) | W'(s);
    else           return cur;
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    if (c[3])      return "R1 clear";
    else if (c[2]) return "R2 set";
    else if (c[1]) return "R3 load";
    else if (c[0]) return "R4 shift";
    else           return "R5 hold";
  endfunction

  // c = {clr, set, ld, shl}; drive at negedge, sample 1 ns after the edge.
  task automatic step(input logic [3:0] c, input logic s, input logic [W-1:0] dv,
                      input string extra);
    @(negedge clk);
    {clr, set, ld, shl} = c;
    sin = s;
    d   = dv;
    model = ref_next(c, s, dv, model);
    @(posedge clk);
    #1;
    check({tag_of(c), extra}, q, model);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: q=%b expected=finished", q);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model = 'x;
    // Reset state by clear, with every other request also high (R1).
    step(4'b1111, 1'b1, 4'hF, " reset");

    // Exhaustive sweep of request combinations from several base values (R6).
    for (int b = 0; b < 3; b++) begin
      for (int c = 0; c < 16; c++) begin
        for (int s = 0; s < 2; s++) begin
          logic [W-1:0] base;
          base = (b == 0) ? 4'h5 : (b == 1) ? 4'hA : 4'h3;
          step(4'b0010, 1'b0, base, " R6 preload");
          step(4'(c), 1'(s), ~base ^ 4'(c), " R6 sweep");
        end
      end
    end

    // Shift chain: top bit drops, serial bits enter at bit 0 (R4).
    step(4'b0010, 1'b0, 4'b1001, " R4 preload");
    step(4'b0001, 1'b1, 4'h0, " R4 chain");
    step(4'b0001, 1'b0, 4'h0, " R4 chain");
    step(4'b0001, 1'b1, 4'h0, " R4 chain");
    step(4'b0001, 1'b1, 4'h0, " R4 chain");

    // Hold ignores d and sin (R5, R6).
    step(4'b0000, 1'b1, 4'hF, " R6 d/sin ignored");
    step(4'b0000, 1'b0, 4'h0, " R6 d/sin ignored");

    // Between edges, q must not move while inputs toggle (R7).
    @(negedge clk);
    {clr, set, ld, shl} = 4'b1100;
    d = ~model;
    #1 check("R7 mid-cycle", q, model);
    {clr, set, ld, shl} = 4'b0010;
    #1 check("R7 mid-cycle", q, model);
    {clr, set, ld, shl} = 4'b0000;
    model = ref_next(4'b0000, sin, d, model);
    @(posedge clk);
    #1 check("R7 after edge", q, model);

    // Random request vectors against the model.
    for (int k = 0; k < 400; k++) begin
      step(4'($urandom), 1'($urandom), 4'($urandom), " random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule